// File: doc/BRIEF.md
# Serial Controller Register Front End

This block sits between a CPU bus and the transmit and receive engines of a programmable serial controller. The CPU sees an 8-bit bidirectional data bus, qualified by an active-low chip select, a control/data select line and active-low read and write strobes. Each access goes to one of three targets: the data path (a transmit byte written or a received byte read), the control path (configuration written), or the status byte (read).

Control writes do not all mean the same thing. A small sequencer tracks how far initialization has progressed. The first control write after reset sets the operating mode. When the mode selects synchronous operation, one or two sync-character writes follow. After that, every control write is a command word. A command with the internal-reset bit set sends the sequencer back to waiting for a mode word. The block holds the decoded mode fields, the sync characters and the transmit/receive enables, and drives them to the serial engines. It also keeps sticky error flags, and it assembles a status byte that stops updating while the CPU is reading it.

Top module: `sio_regif`

## Requirements
- R1: While `cs_n` is high, strobes have no effect. No configuration changes, `tx_load` and `rx_take` stay low, and the block does not drive the bus.
- R2: A write with `cd`=0 captures the bus byte into `tx_data` and raises `tx_load` for exactly one cycle. A read with `cd`=0 returns `rx_data` on the bus and raises `rx_take` for exactly one cycle. Each strobe low period counts as one access, taken on the first clock edge at which the strobe is seen low.
- R3: A read with `cd`=1 returns the status byte. Its bits are: bit0 `tx_rdy_i`, bit1 `rx_rdy_i`, bit2 `tx_empty_i`, bit3 parity error, bit4 overrun, bit5 framing error, bit6 `sync_det_i`, bit7 `dsr_i`.
- R4: The first control write after reset is the mode word. Bits [1:0] set `baud_factor`, where 00 means synchronous. Bits [3:2] give `char_bits` = 5 + value. Bit4 sets `parity_en`, bit5 sets `parity_even` and bits [7:6] set `stop_sel`.
- R5: When a mode word selects an asynchronous rate (bits [1:0] non-zero), every later control write is a command word.
- R6: When a mode word selects synchronous mode, the next control writes load sync characters before commands begin. There is one sync character when mode bit7=1 (`two_sync`=0) and two when bit7=0. The first goes to `sync_char1` and the second to `sync_char2`.
- R7: In a command word, bit0 sets `tx_en` and bit2 sets `rx_en`.
- R8: A command word with bit6 set clears `tx_en` and `rx_en`, and the next control write is taken as a mode word.
- R9: Pulses on `par_err_set`, `ovr_set` and `frm_set` set sticky flags that are reported in status bits 3, 4 and 5. A command word with bit4 set clears all three flags, unless a set pulse arrives in the same cycle.
- R10: The status byte tracks its inputs every cycle, except while a status read is active (`cs_n`=0, `cd`=1, `rd_n`=0). During that read it holds its value.
- R11: Synchronous reset clears every mode, sync and command field. After reset `char_bits` reads 5, the transmitter and receiver are disabled, and the sequencer expects a mode word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| cd | input | 1 | 1 = control/status, 0 = data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dbus | inout | 8 | CPU data bus |
| rx_data | input | 8 | Received byte from the receiver |
| tx_rdy_i | input | 1 | Transmitter ready for a byte |
| rx_rdy_i | input | 1 | Receiver holds a byte |
| tx_empty_i | input | 1 | Transmitter fully idle |
| sync_det_i | input | 1 | Sync/break detected |
| dsr_i | input | 1 | Modem data-set-ready state |
| par_err_set | input | 1 | Parity error pulse |
| ovr_set | input | 1 | Overrun pulse |
| frm_set | input | 1 | Framing error pulse |
| tx_data | output | 8 | Byte written for transmission |
| tx_load | output | 1 | One-cycle pulse: new `tx_data` |
| rx_take | output | 1 | One-cycle pulse: CPU read the received byte |
| baud_factor | output | 2 | Clock-to-baud factor code, 00 = synchronous |
| char_bits | output | 4 | Character length, 5 to 8 |
| stop_sel | output | 2 | Stop-bit length code |
| parity_en | output | 1 | Parity enabled |
| parity_even | output | 1 | Even parity selected |
| sync_mode | output | 1 | Synchronous mode selected |
| two_sync | output | 1 | Two sync characters expected |
| sync_char1 | output | 8 | First sync character |
| sync_char2 | output | 8 | Second sync character |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |

## Verification
The assertions assume that the strobes are synchronous to `clk` and that `rd_n` and `wr_n` are never low together. They also assume that `cs_n`, `cd` and the bus stay stable while a strobe is low, and that the bench releases the bus whenever it reads. The bench meets these conditions by building every access in tasks. Each task changes the inputs on the falling clock edge, holds a strobe low for a single cycle and then returns the lines to idle. Error pulses are always issued well apart from the clearing command, so the clear-versus-set priority is covered only by the property.

// File: rtl/sio_regif_pkg.sv
package sio_regif_pkg;
  typedef enum logic [1:0] {
    SQ_MODE  = 2'd0,
    SQ_SYNC1 = 2'd1,
    SQ_SYNC2 = 2'd2,
    SQ_CMD   = 2'd3
  } seq_t;

  localparam int CMD_TX_EN   = 0;
  localparam int CMD_RX_EN   = 2;
  localparam int CMD_ERR_CLR = 4;
  localparam int CMD_IRESET  = 6;

  localparam int MODE_PAR_EN   = 4;
  localparam int MODE_PAR_EVEN = 5;
  localparam int MODE_ONE_SYNC = 7;

  localparam int NERR = 3;
  localparam int NSYNC = 2;
endpackage

// File: rtl/sio_bus_decode.sv
module sio_bus_decode (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic cd,
  input  logic rd_n,
  input  logic wr_n,
  output logic ctl_wr,
  output logic dat_wr,
  output logic dat_rd,
  output logic rd_stat
);
  logic wr_prev_n;
  logic rd_prev_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev_n <= 1'b1;
      rd_prev_n <= 1'b1;
    end else begin
      wr_prev_n <= wr_n;
      rd_prev_n <= rd_n;
    end
  end

  logic wr_start;
  logic rd_start;
  assign wr_start = ~cs_n & ~wr_n & wr_prev_n;
  assign rd_start = ~cs_n & ~rd_n & rd_prev_n;

  assign ctl_wr  = wr_start & cd;
  assign dat_wr  = wr_start & ~cd;
  assign dat_rd  = rd_start & ~cd;
  assign rd_stat = ~cs_n & cd & ~rd_n;
endmodule

// File: rtl/sio_ctl_seq.sv
module sio_ctl_seq
  import sio_regif_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ctl_wr,
  input  logic [DW-1:0]              wdata,
  output seq_t                       state,
  output logic [DW-1:0]              mode_q,
  output logic [NSYNC-1:0][DW-1:0]   sync_q,
  output logic                       tx_en_q,
  output logic                       rx_en_q,
  output logic                       err_clr
);
  seq_t next_after_mode;
  seq_t next_after_sync1;

  assign next_after_mode  = (wdata[1:0] == 2'b00) ? SQ_SYNC1 : SQ_CMD;
  assign next_after_sync1 = mode_q[MODE_ONE_SYNC] ? SQ_CMD : SQ_SYNC2;
  assign err_clr = ctl_wr && (state == SQ_CMD) && wdata[CMD_ERR_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_MODE;
      mode_q  <= '0;
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
    end else if (ctl_wr) begin
      case (state)
        SQ_MODE: begin
          mode_q <= wdata;
          state  <= next_after_mode;
        end
        SQ_SYNC1: state <= next_after_sync1;
        SQ_SYNC2: state <= SQ_CMD;
        default: begin
          if (wdata[CMD_IRESET]) begin
            tx_en_q <= 1'b0;
            rx_en_q <= 1'b0;
            state   <= SQ_MODE;
          end else begin
            tx_en_q <= wdata[CMD_TX_EN];
            rx_en_q <= wdata[CMD_RX_EN];
          end
        end
      endcase
    end
  end

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    seq_t my_state;
    assign my_state = (g == 0) ? SQ_SYNC1 : SQ_SYNC2;
    always_ff @(posedge clk) begin
      if (rst) sync_q[g] <= '0;
      else if (ctl_wr && state == my_state) sync_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/sio_status.sv
module sio_status
  import sio_regif_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            freeze,
  input  logic            tx_rdy_i,
  input  logic            rx_rdy_i,
  input  logic            tx_empty_i,
  input  logic            sync_det_i,
  input  logic            dsr_i,
  input  logic [NERR-1:0] err_set,
  input  logic            err_clr,
  output logic [NERR-1:0] err_q,
  output logic [DW-1:0]   status_q
);
  logic [DW-1:0] live;

  always_comb begin
    live = '0;
    live[0] = tx_rdy_i;
    live[1] = rx_rdy_i;
    live[2] = tx_empty_i;
    live[3 +: NERR] = err_q;
    live[6] = sync_det_i;
    live[7] = dsr_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q    <= '0;
      status_q <= '0;
    end else begin
      err_q <= (err_q & ~{NERR{err_clr}}) | err_set;
      if (!freeze) status_q <= live;
    end
  end
endmodule

// File: rtl/sio_regif.sv
module sio_regif
  import sio_regif_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          cd,
  input  logic          rd_n,
  input  logic          wr_n,
  inout  wire  [DW-1:0] dbus,
  input  logic [DW-1:0] rx_data,
  input  logic          tx_rdy_i,
  input  logic          rx_rdy_i,
  input  logic          tx_empty_i,
  input  logic          sync_det_i,
  input  logic          dsr_i,
  input  logic          par_err_set,
  input  logic          ovr_set,
  input  logic          frm_set,
  output logic [DW-1:0] tx_data,
  output logic          tx_load,
  output logic          rx_take,
  output logic [1:0]    baud_factor,
  output logic [3:0]    char_bits,
  output logic [1:0]    stop_sel,
  output logic          parity_en,
  output logic          parity_even,
  output logic          sync_mode,
  output logic          two_sync,
  output logic [DW-1:0] sync_char1,
  output logic [DW-1:0] sync_char2,
  output logic          tx_en,
  output logic          rx_en
);
  logic ctl_wr, dat_wr, dat_rd, rd_stat;
  seq_t state;
  logic [DW-1:0] mode_q;
  logic [NSYNC-1:0][DW-1:0] sync_q;
  logic err_clr;
  logic [NERR-1:0] err_set;
  logic [NERR-1:0] err_q;
  logic [DW-1:0] status_q;
  logic [DW-1:0] wdata;

  assign wdata   = dbus;
  assign err_set = {frm_set, ovr_set, par_err_set};

  sio_bus_decode u_dec (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cd(cd), .rd_n(rd_n), .wr_n(wr_n),
    .ctl_wr(ctl_wr), .dat_wr(dat_wr), .dat_rd(dat_rd), .rd_stat(rd_stat)
  );

  sio_ctl_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .wdata(wdata),
    .state(state), .mode_q(mode_q), .sync_q(sync_q),
    .tx_en_q(tx_en), .rx_en_q(rx_en), .err_clr(err_clr)
  );

  sio_status #(.DW(DW)) u_stat (
    .clk(clk), .rst(rst), .freeze(rd_stat),
    .tx_rdy_i(tx_rdy_i), .rx_rdy_i(rx_rdy_i), .tx_empty_i(tx_empty_i),
    .sync_det_i(sync_det_i), .dsr_i(dsr_i),
    .err_set(err_set), .err_clr(err_clr), .err_q(err_q), .status_q(status_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_data <= '0;
      tx_load <= 1'b0;
      rx_take <= 1'b0;
    end else begin
      if (dat_wr) tx_data <= wdata;
      tx_load <= dat_wr;
      rx_take <= dat_rd;
    end
  end

  assign dbus = (~cs_n & ~rd_n) ? (cd ? status_q : rx_data) : 'z;

  assign baud_factor = mode_q[1:0];
  assign char_bits   = 4'd5 + {2'b00, mode_q[3:2]};
  assign stop_sel    = mode_q[7:6];
  assign parity_en   = mode_q[MODE_PAR_EN];
  assign parity_even = mode_q[MODE_PAR_EVEN];
  assign sync_mode   = (mode_q[1:0] == 2'b00);
  assign two_sync    = sync_mode & ~mode_q[MODE_ONE_SYNC];
  assign sync_char1  = sync_q[0];
  assign sync_char2  = sync_q[1];
endmodule

// File: rtl/sio_regif_chk.sv
module sio_regif_chk
  import sio_regif_pkg::*;
#(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            cs_n,
  input logic            tx_load,
  input logic            rx_take,
  input logic            ctl_wr,
  input logic [DW-1:0]   wdata,
  input seq_t            state,
  input logic            tx_en,
  input logic            rx_en,
  input logic            rd_stat,
  input logic [DW-1:0]   status_q,
  input logic            err_clr,
  input logic [NERR-1:0] err_set,
  input logic [NERR-1:0] err_q
);
  a_r1_cs_blocks: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!tx_load && !rx_take));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> !tx_load);

  a_r5_async_to_cmd: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_MODE && ctl_wr && wdata[1:0] != 2'b00) |=> (state == SQ_CMD));

  a_r8_ireset: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_CMD && ctl_wr && wdata[CMD_IRESET]) |=>
      (state == SQ_MODE && !tx_en && !rx_en));

  a_r9_err_clear: assert property (@(posedge clk) disable iff (rst)
    (err_clr && err_set == '0) |=> (err_q == '0));

  a_r10_freeze: assert property (@(posedge clk) disable iff (rst)
    $past(rd_stat) |-> $stable(status_q));
endmodule

bind sio_regif sio_regif_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .tx_load(tx_load), .rx_take(rx_take),
  .ctl_wr(ctl_wr), .wdata(wdata), .state(state), .tx_en(tx_en), .rx_en(rx_en),
  .rd_stat(rd_stat), .status_q(status_q), .err_clr(err_clr),
  .err_set(err_set), .err_q(err_q)
);

// File: tb/sio_regif_test.sv
module sio_regif_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic cs_n = 1'b1, cd = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] drv = 8'h00;
  logic drv_oe = 1'b0;
  wire  [7:0] dbus;
  assign dbus = drv_oe ? drv : 8'hzz;

  logic [7:0] rx_data = 8'h3C;
  logic tx_rdy_i = 1'b1, rx_rdy_i = 1'b0, tx_empty_i = 1'b0, sync_det_i = 1'b0, dsr_i = 1'b0;
  logic par_err_set = 1'b0, ovr_set = 1'b0, frm_set = 1'b0;
  logic [7:0] tx_data, sync_char1, sync_char2;
  logic tx_load, rx_take, parity_en, parity_even, sync_mode, two_sync, tx_en, rx_en;
  logic [1:0] baud_factor, stop_sel;
  logic [3:0] char_bits;

  sio_regif uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cd(cd), .rd_n(rd_n), .wr_n(wr_n),
    .dbus(dbus), .rx_data(rx_data), .tx_rdy_i(tx_rdy_i), .rx_rdy_i(rx_rdy_i),
    .tx_empty_i(tx_empty_i), .sync_det_i(sync_det_i), .dsr_i(dsr_i),
    .par_err_set(par_err_set), .ovr_set(ovr_set), .frm_set(frm_set),
    .tx_data(tx_data), .tx_load(tx_load), .rx_take(rx_take),
    .baud_factor(baud_factor), .char_bits(char_bits), .stop_sel(stop_sel),
    .parity_en(parity_en), .parity_even(parity_even), .sync_mode(sync_mode),
    .two_sync(two_sync), .sync_char1(sync_char1), .sync_char2(sync_char2),
    .tx_en(tx_en), .rx_en(rx_en)
  );

  int checks = 0, errors = 0;
  int loads = 0, takes = 0;
  logic done = 1'b0;

  always @(posedge clk) begin
    if (!rst && tx_load) loads <= loads + 1;
    if (!rst && rx_take) takes <= takes + 1;
  end

  function automatic logic [7:0] obs(input logic [2:0] sel, input logic [7:0] rd);
    case (sel)
      3'd1: obs = rd;
      3'd2: obs = {stop_sel, parity_even, parity_en, char_bits};
      3'd3: obs = {4'b0, rx_en, tx_en, baud_factor};
      3'd4: obs = sync_char1;
      3'd5: obs = sync_char2;
      default: obs = tx_data;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic c, input logic [7:0] d, input logic sel_n);
    @(negedge clk);
    cs_n = sel_n; cd = c; drv = d; drv_oe = 1'b1; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; drv_oe = 1'b0; cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read(input logic c, input logic sel_n, output logic [7:0] v);
    @(negedge clk);
    cs_n = sel_n; cd = c; rd_n = 1'b0;
    @(negedge clk);
    v = dbus;
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // {op(1=read), cd, data, obs select, expected}
  localparam int NV = 15;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h4E, 3'd2, 8'h48},  // R4 mode: 16x, 8 bits, stop 01
    {1'b0, 1'b1, 8'h05, 3'd3, 8'h0E},  // R7 R5 command tx+rx
    {1'b0, 1'b1, 8'h01, 3'd3, 8'h06},  // R5 later write is command
    {1'b0, 1'b0, 8'hA5, 3'd6, 8'hA5},  // R2 data write
    {1'b1, 1'b0, 8'h00, 3'd1, 8'h3C},  // R2 data read
    {1'b1, 1'b1, 8'h00, 3'd1, 8'h01},  // R3 status, tx ready only
    {1'b0, 1'b1, 8'h40, 3'd3, 8'h02},  // R8 internal reset
    {1'b0, 1'b1, 8'h3C, 3'd2, 8'h38},  // R4 R6 sync mode, even parity, two sync
    {1'b0, 1'b1, 8'h16, 3'd4, 8'h16},  // R6 first sync char
    {1'b0, 1'b1, 8'h27, 3'd5, 8'h27},  // R6 second sync char
    {1'b0, 1'b1, 8'h04, 3'd3, 8'h08},  // R6 then command, rx only
    {1'b0, 1'b1, 8'h40, 3'd3, 8'h00},  // R8 internal reset again
    {1'b0, 1'b1, 8'hCC, 3'd2, 8'hC8},  // R6 sync mode, one sync char
    {1'b0, 1'b1, 8'h5A, 3'd4, 8'h5A},  // R6 single sync char
    {1'b0, 1'b1, 8'h01, 3'd3, 8'h04}   // R6 command directly after one sync
  };

  function automatic string tag_of(input int i);
    case (i)
      0: tag_of = "R4"; 1: tag_of = "R7"; 2: tag_of = "R5"; 3: tag_of = "R2";
      4: tag_of = "R2"; 5: tag_of = "R3"; 6: tag_of = "R8"; 11: tag_of = "R8";
      default: tag_of = "R6";
    endcase
  endfunction

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 cmd fields", obs(3'd3, 8'h00), 8'h00);
    check("R11 mode fields", obs(3'd2, 8'h00), 8'h05);

    for (int i = 0; i < NV; i++) begin
      rv = 8'h00;
      if (VEC[i][20]) do_read(VEC[i][19], 1'b0, rv);
      else do_write(VEC[i][19], VEC[i][18:11], 1'b0);
      check(tag_of(i), obs(VEC[i][10:8], rv), VEC[i][7:0]);
    end

    // R1: deselected strobes are ignored
    do_write(1'b1, 8'h41, 1'b1);
    check("R1 cfg unchanged", obs(3'd3, 8'h00), 8'h04);
    do_read(1'b0, 1'b1, rv);
    check("R1 no rx_take", 8'(takes), 8'd1);
    check("R2 one tx_load total", 8'(loads), 8'd1);
    do_write(1'b1, 8'h05, 1'b0);
    check("R1 still in command", obs(3'd3, 8'h00), 8'h0C);

    // R9 sticky error and clear
    tx_rdy_i = 1'b0;
    @(negedge clk); ovr_set = 1'b1;
    @(negedge clk); ovr_set = 1'b0;
    repeat (3) @(negedge clk);
    do_read(1'b1, 1'b0, rv);
    check("R9 overrun set", rv, 8'h10);
    @(negedge clk); frm_set = 1'b1; par_err_set = 1'b1;
    @(negedge clk); frm_set = 1'b0; par_err_set = 1'b0;
    repeat (3) @(negedge clk);
    do_read(1'b1, 1'b0, rv);
    check("R9 all errors", rv, 8'h38);
    do_write(1'b1, 8'h10, 1'b0);
    do_read(1'b1, 1'b0, rv);
    check("R9 cleared", rv, 8'h00);

    // R10 freeze during status read
    @(negedge clk);
    cs_n = 1'b0; cd = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    tx_empty_i = 1'b1; dsr_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 held during read", dbus, 8'h00);
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (3) @(negedge clk);
    do_read(1'b1, 1'b0, rv);
    check("R10 R3 updated after read", rv, 8'h84);

    // R11 hardware reset, then mode is first again
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R11 cmd cleared", obs(3'd3, 8'h00), 8'h00);
    check("R11 mode cleared", obs(3'd2, 8'h00), 8'h05);
    check("R11 sync cleared", obs(3'd4, 8'h00), 8'h00);
    do_write(1'b1, 8'h4E, 1'b0);
    check("R11 R4 first write is mode", obs(3'd2, 8'h00), 8'h48);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule